// File: doc/BRIEF.md
# Operand-2 Barrel Shifter with Carry

This block builds the second ALU operand of a 32-bit RISC datapath. In register form it shifts or rotates the operand register by an amount that comes either from a 5-bit instruction field or from the low byte of a second register. In immediate form it expands a 12-bit field into a 32-bit constant by rotating an 8-bit value right by twice a 4-bit rotate count. Every operation also returns the shifter carry. Logical and move instructions use this carry as their C flag.

The result and carry are combinational. The only state in the block is a one-bit phase flag. When the shift amount comes from a register, the block requests one stall cycle, because that amount needs a third register read. The pipeline keeps the operation on the inputs for the extra cycle.

Shift-kind code: 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, 2'b11 rotate right. There is no rotate-left or arithmetic-left code. A rotate left by n is issued as a rotate right by 32-n.

Top module: `op2_shifter`

## Requirements
- R1: Logical left by n, for n from 1 to 31, gives operand<<n with carry equal to operand bit 32-n. An immediate amount of 0 passes the operand through and keeps carry_in.
- R2: Logical right by n, for n from 1 to 31, gives operand>>n with carry equal to operand bit n-1. An immediate amount of 0 means a shift of 32: the result is 0 and the carry is operand bit 31.
- R3: Arithmetic right fills with the sign bit, with carry equal to the last bit shifted out. An immediate amount of 0 means 32: every result bit is the sign bit and the carry is the sign bit.
- R4: Rotate right by a nonzero immediate amount rotates the operand, and the carry equals result bit 31.
- R5: Rotate right with an immediate amount of 0 is a 33-bit rotate through carry: the result is {carry_in, operand[31:1]} and the carry is operand bit 0.
- R6: When use_imm=1, the result is zero-extended imm12[7:0] rotated right by 2*imm12[11:8]. The carry is carry_in when imm12[11:8]=0 and result bit 31 otherwise. The operand, shift kind and amount inputs are ignored, and stall stays low.
- R7: When amt_sel=1, the amount is the unsigned shamt_reg byte. A byte of 0 leaves both the operand and carry_in unchanged for every shift kind.
- R8: A register amount of exactly 32 gives result 0 for both logical shifts, with carry equal to operand bit 0 (left) or bit 31 (right). An amount above 32 gives result 0 and carry 0.
- R9: An arithmetic right by a register amount of 32 or more gives all sign bits, with the sign bit as carry.
- R10: A rotate right by a nonzero register amount uses the amount modulo 32, and the carry equals result bit 31. A multiple of 32 returns the operand with carry equal to operand bit 31.
- R11: stall is high for exactly the first cycle of an in_valid register-form operation that has amt_sel=1. It is low in the second cycle, and it is never high for an immediate-amount operation.
- R12: Reset clears the phase flag. The first register-amount operation after reset therefore stalls, including when reset lands in the middle of a stalled pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| use_imm | input | 1 | 1 = rotated-immediate form, 0 = register form |
| shift_kind | input | 2 | 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| amt_sel | input | 1 | 1 = amount from shamt_reg, 0 = from amt_imm |
| amt_imm | input | 5 | Immediate shift amount |
| shamt_reg | input | 8 | Low byte of the amount register |
| imm12 | input | 12 | Rotate count [11:8] and byte value [7:0] |
| carry_in | input | 1 | Current carry flag |
| operand | input | 32 | Register operand to shift |
| result | output | 32 | Shifted second operand |
| carry_out | output | 1 | Shifter carry |
| stall | output | 1 | Request one extra cycle |

## Verification
The clocked properties sample combinational paths at the rising edge. They therefore assume that every input is known and stable across that edge, and that in_valid is low while reset is asserted. The bench changes inputs only just after a falling edge and checks them before the next rising edge. It drives no unknown values and keeps in_valid low during reset. The one exception is the mid-pair reset test, where reset is asserted while in_valid is high and the assertions are disabled.

// File: rtl/op2_shifter.sv
module op2_shifter #(
  parameter int DW = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic                    use_imm,
  input  logic [1:0]              shift_kind,
  input  logic                    amt_sel,
  input  logic [$clog2(DW)-1:0]   amt_imm,
  input  logic [7:0]              shamt_reg,
  input  logic [11:0]             imm12,
  input  logic                    carry_in,
  input  logic [DW-1:0]           operand,
  output logic [DW-1:0]           result,
  output logic                    carry_out,
  output logic                    stall
);
  localparam int AW = $clog2(DW);
  localparam int EW = AW + 1;
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;
  localparam logic [7:0] B_DW  = 8'(DW);
  localparam logic [EW-1:0] E_DW  = EW'(DW);
  localparam logic [EW-1:0] E_DW1 = EW'(DW + 1);

  logic          second_q;
  logic          reg_zero, imm_zero;
  logic [EW-1:0] e;
  logic [DW:0]   lsl_w, lsr_w, asr_w;
  logic [DW-1:0] ror_r, imm_byte, imm_rot;

  assign stall    = in_valid & ~use_imm & amt_sel & ~second_q;
  assign reg_zero = amt_sel & (shamt_reg == 8'd0);
  assign imm_zero = ~amt_sel & (amt_imm == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) second_q <= 1'b0;
    else        second_q <= stall;

  always_comb begin
    case (shift_kind)
      K_LSL, K_LSR:
        e = amt_sel ? ((shamt_reg > B_DW) ? E_DW1 : EW'(shamt_reg))
                    : (imm_zero && shift_kind == K_LSR ? E_DW : {1'b0, amt_imm});
      K_ASR:
        e = amt_sel ? ((shamt_reg >= B_DW) ? E_DW : EW'(shamt_reg))
                    : (imm_zero ? E_DW : {1'b0, amt_imm});
      default:
        e = amt_sel ? {1'b0, shamt_reg[AW-1:0]} : {1'b0, amt_imm};
    endcase
  end

  assign lsl_w    = {1'b0, operand} << e;
  assign lsr_w    = {operand, 1'b0} >> e;
  assign asr_w    = $unsigned($signed({operand, 1'b0}) >>> e);
  assign ror_r    = DW'({operand, operand} >> e);
  assign imm_byte = {{(DW-8){1'b0}}, imm12[7:0]};
  assign imm_rot  = DW'({imm_byte, imm_byte} >> {imm12[11:8], 1'b0});

  always_comb begin
    result    = operand;
    carry_out = carry_in;
    if (use_imm) begin
      result    = imm_rot;
      carry_out = (imm12[11:8] == 4'd0) ? carry_in : imm_rot[DW-1];
    end else if (!reg_zero) begin
      case (shift_kind)
        K_LSL: if (e != '0) begin
          result    = lsl_w[DW-1:0];
          carry_out = lsl_w[DW];
        end
        K_LSR: begin
          result    = lsr_w[DW:1];
          carry_out = lsr_w[0];
        end
        K_ASR: begin
          result    = asr_w[DW:1];
          carry_out = asr_w[0];
        end
        default: if (imm_zero) begin
          result    = {carry_in, operand[DW-1:1]};
          carry_out = operand[0];
        end else begin
          result    = ror_r;
          carry_out = ror_r[DW-1];
        end
      endcase
    end
  end
endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
  parameter int DW = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  use_imm,
  input logic [1:0]            shift_kind,
  input logic                  amt_sel,
  input logic [$clog2(DW)-1:0] amt_imm,
  input logic [7:0]            shamt_reg,
  input logic [11:0]           imm12,
  input logic                  carry_in,
  input logic [DW-1:0]         operand,
  input logic [DW-1:0]         result,
  input logic                  carry_out,
  input logic                  stall
);
  assert_stall_one_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  assert_stall_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !use_imm && amt_sel && !$past(stall)) |-> stall);

  assert_no_stall_imm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm || !amt_sel) |-> !stall);

  assert_imm_norot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (use_imm && imm12[11:8] == 4'd0) |->
      (result == {{(DW-8){1'b0}}, imm12[7:0]} && carry_out == carry_in));

  assert_reg_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_imm && amt_sel && shamt_reg == 8'd0) |->
      (result == operand && carry_out == carry_in));

  assert_lsl_big_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_imm && amt_sel && shift_kind == 2'b00 && shamt_reg > 8'd32) |->
      (result == '0 && !carry_out));

  assert_asr_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_imm && shift_kind == 2'b10) |-> (result[DW-1] == operand[DW-1]));

  assert_ror_carry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!use_imm && shift_kind == 2'b11 && !(amt_sel && shamt_reg == 8'd0) &&
     !(!amt_sel && amt_imm == '0)) |-> (carry_out == result[DW-1]));
endmodule

bind op2_shifter op2_shifter_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_imm(use_imm),
  .shift_kind(shift_kind), .amt_sel(amt_sel), .amt_imm(amt_imm),
  .shamt_reg(shamt_reg), .imm12(imm12), .carry_in(carry_in),
  .operand(operand), .result(result), .carry_out(carry_out), .stall(stall)
);

// File: tb/tb_op2_shifter.sv
`timescale 1ns/1ps
module tb_op2_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, use_imm = 1'b0, amt_sel = 1'b0, carry_in = 1'b0;
  logic [1:0]  shift_kind = 2'b00;
  logic [4:0]  amt_imm = '0;
  logic [7:0]  shamt_reg = '0;
  logic [11:0] imm12 = '0;
  logic [31:0] operand = '0;
  logic [31:0] result;
  logic        carry_out, stall;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  op2_shifter dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .use_imm(use_imm),
    .shift_kind(shift_kind), .amt_sel(amt_sel), .amt_imm(amt_imm),
    .shamt_reg(shamt_reg), .imm12(imm12), .carry_in(carry_in),
    .operand(operand), .result(result), .carry_out(carry_out), .stall(stall)
  );

  // {use_imm, kind, amt_sel, amt_imm, shamt_reg, imm12, cin, operand, exp_res, exp_c, req}
  localparam int NV = 28;
  localparam logic [98:0] VEC [NV] = '{
    {1'b0,2'd0,1'b0,5'd4, 8'd0,  12'h000,1'b0,32'hF000000F,32'h000000F0,1'b1,4'd1},  // R1
    {1'b0,2'd0,1'b0,5'd0, 8'd0,  12'h000,1'b1,32'h12345678,32'h12345678,1'b1,4'd1},  // R1
    {1'b0,2'd0,1'b0,5'd1, 8'd0,  12'h000,1'b0,32'h80000000,32'h00000000,1'b1,4'd1},  // R1
    {1'b0,2'd1,1'b0,5'd4, 8'd0,  12'h000,1'b0,32'hF000000F,32'h0F000000,1'b1,4'd2},  // R2
    {1'b0,2'd1,1'b0,5'd0, 8'd0,  12'h000,1'b0,32'h80000000,32'h00000000,1'b1,4'd2},  // R2
    {1'b0,2'd1,1'b0,5'd1, 8'd0,  12'h000,1'b1,32'h00000002,32'h00000001,1'b0,4'd2},  // R2
    {1'b0,2'd2,1'b0,5'd4, 8'd0,  12'h000,1'b1,32'h80000010,32'hF8000001,1'b0,4'd3},  // R3
    {1'b0,2'd2,1'b0,5'd0, 8'd0,  12'h000,1'b0,32'h80000000,32'hFFFFFFFF,1'b1,4'd3},  // R3
    {1'b0,2'd2,1'b0,5'd0, 8'd0,  12'h000,1'b1,32'h7FFFFFFF,32'h00000000,1'b0,4'd3},  // R3
    {1'b0,2'd3,1'b0,5'd8, 8'd0,  12'h000,1'b1,32'h12345678,32'h78123456,1'b0,4'd4},  // R4
    {1'b0,2'd3,1'b0,5'd1, 8'd0,  12'h000,1'b0,32'h00000001,32'h80000000,1'b1,4'd4},  // R4
    {1'b0,2'd3,1'b0,5'd0, 8'd0,  12'h000,1'b1,32'h00000003,32'h80000001,1'b1,4'd5},  // R5
    {1'b0,2'd3,1'b0,5'd0, 8'd0,  12'h000,1'b0,32'h00000002,32'h00000001,1'b0,4'd5},  // R5
    {1'b1,2'd0,1'b1,5'd7, 8'd3,  12'h43F,1'b1,32'hDEADBEEF,32'h3F000000,1'b0,4'd6},  // R6
    {1'b1,2'd2,1'b0,5'd9, 8'd0,  12'h0A5,1'b1,32'h01234567,32'h000000A5,1'b1,4'd6},  // R6
    {1'b1,2'd3,1'b0,5'd0, 8'd0,  12'h1FF,1'b0,32'hFFFFFFFF,32'hC000003F,1'b1,4'd6},  // R6
    {1'b0,2'd1,1'b1,5'd9, 8'd0,  12'h000,1'b1,32'h87654321,32'h87654321,1'b1,4'd7},  // R7
    {1'b0,2'd0,1'b1,5'd0, 8'd4,  12'h000,1'b0,32'hF000000F,32'h000000F0,1'b1,4'd7},  // R7
    {1'b0,2'd1,1'b1,5'd3, 8'd31, 12'h000,1'b1,32'h80000000,32'h00000001,1'b0,4'd7},  // R7
    {1'b0,2'd0,1'b1,5'd0, 8'd32, 12'h000,1'b0,32'h00000001,32'h00000000,1'b1,4'd8},  // R8
    {1'b0,2'd0,1'b1,5'd0, 8'd33, 12'h000,1'b1,32'hFFFFFFFF,32'h00000000,1'b0,4'd8},  // R8
    {1'b0,2'd1,1'b1,5'd0, 8'd32, 12'h000,1'b0,32'h80000000,32'h00000000,1'b1,4'd8},  // R8
    {1'b0,2'd1,1'b1,5'd0, 8'd200,12'h000,1'b1,32'hFFFFFFFF,32'h00000000,1'b0,4'd8},  // R8
    {1'b0,2'd2,1'b1,5'd0, 8'd40, 12'h000,1'b0,32'h80000000,32'hFFFFFFFF,1'b1,4'd9},  // R9
    {1'b0,2'd2,1'b1,5'd0, 8'd32, 12'h000,1'b1,32'h40000000,32'h00000000,1'b0,4'd9},  // R9
    {1'b0,2'd3,1'b1,5'd0, 8'd36, 12'h000,1'b0,32'h0000000F,32'hF0000000,1'b1,4'd10}, // R10
    {1'b0,2'd3,1'b1,5'd0, 8'd64, 12'h000,1'b0,32'h80000000,32'h80000000,1'b1,4'd10}, // R10
    {1'b0,2'd3,1'b1,5'd0, 8'd32, 12'h000,1'b1,32'h00000001,32'h00000001,1'b0,4'd10}  // R10
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) at_neg();
    check(stall == 1'b0, "R12 stall in reset", 32'(stall), 32'd0);
    rst_n = 1'b1;
    at_neg();
    check(stall == 1'b0, "R12 stall after reset", 32'(stall), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [98:0] v;
      v = VEC[i];
      {use_imm, shift_kind, amt_sel, amt_imm, shamt_reg, imm12, carry_in, operand} = v[98:37];
      #4;
      check(result == v[36:5], $sformatf("R%0d result vec %0d", v[3:0], i), result, v[36:5]);
      check(carry_out == v[4], $sformatf("R%0d carry vec %0d", v[3:0], i), 32'(carry_out), 32'(v[4]));
      at_neg();
    end

    // R11 / R12: stall sequence
    use_imm = 1'b0; amt_sel = 1'b1; shamt_reg = 8'd3; shift_kind = 2'b00;
    at_neg();
    in_valid = 1'b1; #1;
    check(stall == 1'b1, "R12 first reg op stalls", 32'(stall), 32'd1);
    at_neg();
    check(stall == 1'b0, "R11 second cycle no stall", 32'(stall), 32'd0);
    at_neg();
    check(stall == 1'b1, "R11 next reg op stalls", 32'(stall), 32'd1);
    at_neg();
    check(stall == 1'b0, "R11 next op second cycle", 32'(stall), 32'd0);
    amt_sel = 1'b0;
    at_neg();
    check(stall == 1'b0, "R11 imm amount no stall", 32'(stall), 32'd0);
    use_imm = 1'b1; amt_sel = 1'b1; #1;
    check(stall == 1'b0, "R6 imm operand no stall", 32'(stall), 32'd0);
    use_imm = 1'b0; in_valid = 1'b0; #1;
    check(stall == 1'b0, "R11 idle no stall", 32'(stall), 32'd0);

    // R12: reset in middle of a stalled pair
    at_neg();
    in_valid = 1'b1; #1;
    check(stall == 1'b1, "R11 stall before reset", 32'(stall), 32'd1);
    at_neg();
    rst_n = 1'b0; #1;
    check(stall == 1'b1, "R12 reset clears phase", 32'(stall), 32'd1);
    in_valid = 1'b0;
    at_neg();
    rst_n = 1'b1;
    at_neg();
    in_valid = 1'b1; #1;
    check(stall == 1'b1, "R12 stall after mid reset", 32'(stall), 32'd1);
    at_neg();
    in_valid = 1'b0;
    at_neg();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule